// File: doc/BRIEF.md
# Two-Pin Mode Sequence Detector

A small control block that sits beside a serial LED driver core and decides whether the core runs in normal mode or in diagnostic (error-detection) mode. No pin is dedicated to the mode. The block instead samples the two control inputs that serve other purposes day to day: the latch strobe and the output blanking input. It samples them on every rising clock edge and looks for one of two fixed five-edge patterns. The pattern that opens diagnostic mode raises the strobe on its fourth step. The pattern that closes it keeps the strobe low throughout. Both share the blanking shape high, low, high, high, high.

Only the pattern opposite to the present mode is tracked, so the two sequences must alternate. A repeat of the sequence that was just used changes nothing. To run a second diagnosis, the controller must first return to normal mode. On entry, the block raises a single-cycle start pulse one edge after the mode flag rises. The pulse marks where the serial input may begin to be sampled as diagnostic data. The block has no data path, so every port is a plain control or status line with no handshake.

Top module: `seqdet_mode_switch`

## Requirements
- R1: A synchronous active-high reset puts the block in normal mode (diag_mode_o = 0), drives sample_start_o low and clears any partial pattern progress.
- R2: In normal mode, five consecutive rising edges that sample blank_i = 1,0,1,1,1 together with strobe_i = 0,0,0,1,0 switch the block to diagnostic mode (diag_mode_o = 1).
- R3: diag_mode_o changes on the rising edge that samples the fifth matching step. After only four matching steps it has not yet changed.
- R4: sample_start_o is high for exactly one cycle. It rises on the edge after the one that set diag_mode_o, and it is only raised on entry into diagnostic mode.
- R5: In diagnostic mode, five consecutive rising edges that sample blank_i = 1,0,1,1,1 with strobe_i = 0 on every edge return the block to normal mode, and no start pulse is produced.
- R6: A full entry sequence given while in diagnostic mode, or a full return sequence given while in normal mode, leaves diag_mode_o and sample_start_o unchanged.
- R7: A sample that breaks the expected pattern drops the progress to step 0. If that sample equals the first step (blank_i = 1, strobe_i = 0), progress drops to step 1 instead, and the sequence may continue from there.
- R8: Ordinary strobe and blanking activity that does not complete the expected pattern never changes the mode. A valid sequence that follows such activity is still recognised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both control inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| blank_i | input | 1 | Output blanking control level (high = outputs dark) |
| strobe_i | input | 1 | Latch strobe control level |
| diag_mode_o | output | 1 | 1 while in diagnostic mode, 0 in normal mode |
| sample_start_o | output | 1 | One-cycle pulse marking the start of diagnostic data sampling |

## Verification
The detector is tried with clean entry and return sequences, which show the exact edge of the mode change and of the start pulse. It is also given repeated same-direction sequences, which separate a detector that tracks only the opposite pattern from one that toggles on either. Sequences are broken at every step, and one is broken by a sample equal to the first step, which tells a restart to step 1 apart from a plain clear. Long runs of random strobe and blanking activity with sequences embedded in them check, against a reference model in the bench, that ordinary traffic never changes the mode and never hides a valid sequence.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

  // Number of sampled edges in either mode-change pattern.
  localparam int unsigned STEPS = 5;

  // Bit i holds the level expected on the i-th sampled edge.
  localparam logic [STEPS-1:0] ENTER_BLANK  = 5'b11101;
  localparam logic [STEPS-1:0] ENTER_STROBE = 5'b01000;
  localparam logic [STEPS-1:0] EXIT_BLANK   = 5'b11101;
  localparam logic [STEPS-1:0] EXIT_STROBE  = 5'b00000;

  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_DIAG   = 1'b1
  } op_mode_e;

endpackage

// File: rtl/seqdet_matcher.sv
module seqdet_matcher #(
  parameter int unsigned SEQ_LEN = 5,
  parameter int unsigned CNT_W   = 3,
  parameter logic [SEQ_LEN-1:0] ENTER_BLANK  = 5'b11101,
  parameter logic [SEQ_LEN-1:0] ENTER_STROBE = 5'b01000,
  parameter logic [SEQ_LEN-1:0] EXIT_BLANK   = 5'b11101,
  parameter logic [SEQ_LEN-1:0] EXIT_STROBE  = 5'b00000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             use_exit_i,
  input  logic             blank_i,
  input  logic             strobe_i,
  output logic             done_o,
  output logic [CNT_W-1:0] step_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(SEQ_LEN - 1);

  logic [SEQ_LEN-1:0] hit_enter;
  logic [SEQ_LEN-1:0] hit_exit;
  logic [SEQ_LEN-1:0] hit;
  logic [CNT_W-1:0]   step_q;
  logic               cur_hit;

  // Per-step comparison of the present sample against both tables.
  for (genvar i = 0; i < SEQ_LEN; i++) begin : g_step
    assign hit_enter[i] = (blank_i == ENTER_BLANK[i]) && (strobe_i == ENTER_STROBE[i]);
    assign hit_exit[i]  = (blank_i == EXIT_BLANK[i])  && (strobe_i == EXIT_STROBE[i]);
  end

  // Only the pattern leading away from the current mode is tracked.
  assign hit = use_exit_i ? hit_exit : hit_enter;

  always_comb begin
    cur_hit = 1'b0;
    for (int i = 0; i < SEQ_LEN; i++) begin
      if (step_q == CNT_W'(i)) cur_hit = hit[i];
    end
  end

  assign done_o = cur_hit && (step_q == LAST);
  assign step_o = step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= '0;
    end else if (cur_hit) begin
      step_q <= done_o ? '0 : step_q + 1'b1;
    end else begin
      step_q <= hit[0] ? CNT_W'(1) : '0;
    end
  end

endmodule

// File: rtl/seqdet_mode_reg.sv
module seqdet_mode_reg
  import seqdet_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     done_i,
  output op_mode_e mode_o,
  output logic     start_o
);

  op_mode_e mode_q;
  logic     pend_q;
  logic     start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_NORMAL;
      pend_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      pend_q  <= done_i && (mode_q == MODE_NORMAL);
      start_q <= pend_q;
      if (done_i) begin
        mode_q <= (mode_q == MODE_NORMAL) ? MODE_DIAG : MODE_NORMAL;
      end
    end
  end

  assign mode_o  = mode_q;
  assign start_o = start_q;

endmodule

// File: rtl/seqdet_mode_switch.sv
module seqdet_mode_switch
  import seqdet_pkg::*;
#(
  parameter int unsigned SEQ_LEN = STEPS,
  parameter int unsigned CNT_W   = $clog2(SEQ_LEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic blank_i,
  input  logic strobe_i,
  output logic diag_mode_o,
  output logic sample_start_o
);

  logic             done_w;
  logic [CNT_W-1:0] step_w;
  op_mode_e         mode_w;

  seqdet_matcher #(
    .SEQ_LEN     (SEQ_LEN),
    .CNT_W       (CNT_W),
    .ENTER_BLANK (ENTER_BLANK),
    .ENTER_STROBE(ENTER_STROBE),
    .EXIT_BLANK  (EXIT_BLANK),
    .EXIT_STROBE (EXIT_STROBE)
  ) u_match (
    .clk       (clk),
    .rst       (rst),
    .use_exit_i(diag_mode_o),
    .blank_i   (blank_i),
    .strobe_i  (strobe_i),
    .done_o    (done_w),
    .step_o    (step_w)
  );

  seqdet_mode_reg u_mode (
    .clk    (clk),
    .rst    (rst),
    .done_i (done_w),
    .mode_o (mode_w),
    .start_o(sample_start_o)
  );

  assign diag_mode_o = (mode_w == MODE_DIAG);

endmodule

// File: rtl/seqdet_mode_switch_chk.sv
module seqdet_mode_switch_chk #(
  parameter int unsigned SEQ_LEN = 5,
  parameter int unsigned CNT_W   = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             diag,
  input logic             start,
  input logic [CNT_W-1:0] step
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(SEQ_LEN - 1);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R1: after an edge that sampled reset, everything is cleared
  always @(negedge clk) begin
    if (rst_q === 1'b1) begin
      assert_reset_clear_R1: assert (!diag && !start && step == '0)
        else $error("R1 reset state not reached");
    end
  end

  // R3: mode only flips when the previous edge held the final step
  assert_flip_at_last_R3: assert property (@(posedge clk) disable iff (rst || rst_q)
    (diag != $past(diag)) |-> ($past(step) == LAST));

  // R4: start pulse lasts a single cycle
  assert_start_single_R4: assert property (@(posedge clk) disable iff (rst)
    start |=> !start);

  // R4: start pulse only appears in diagnostic mode
  assert_start_in_diag_R4: assert property (@(posedge clk) disable iff (rst)
    start |-> diag);

  // R4: entry is followed by the start pulse one edge later
  assert_start_follows_entry_R4: assert property (@(posedge clk) disable iff (rst || rst_q)
    $rose(diag) |=> start);

  // R5: leaving diagnostic mode never produces a start pulse
  assert_no_start_on_exit_R5: assert property (@(posedge clk) disable iff (rst || rst_q)
    $fell(diag) |-> !start);

  // R7: progress counter stays within the pattern length
  assert_step_range_R7: assert property (@(posedge clk) disable iff (rst)
    step <= LAST);

endmodule

bind seqdet_mode_switch seqdet_mode_switch_chk #(
  .SEQ_LEN(SEQ_LEN),
  .CNT_W  (CNT_W)
) u_chk (
  .clk  (clk),
  .rst  (rst),
  .diag (diag_mode_o),
  .start(sample_start_o),
  .step (step_w)
);

// File: tb/seqdet_mode_switch_test.sv
module seqdet_mode_switch_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic blank = 1'b1;
  logic strobe = 1'b0;
  logic diag_mode;
  logic sample_start;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;

  // Reference model state
  logic m_diag = 1'b0;
  int   m_step = 0;
  logic m_pend = 1'b0;
  logic m_start = 1'b0;

  seqdet_mode_switch uut (
    .clk           (clk),
    .rst           (rst),
    .blank_i       (blank),
    .strobe_i      (strobe),
    .diag_mode_o   (diag_mode),
    .sample_start_o(sample_start)
  );

  always #5 clk = ~clk;

  // Expected levels per step, from the requirements (R2, R5).
  function automatic logic exp_blank(int k);
    return (k == 1) ? 1'b0 : 1'b1;
  endfunction

  function automatic logic exp_strobe(logic in_diag, int k);
    return (!in_diag && k == 3) ? 1'b1 : 1'b0;
  endfunction

  function automatic bit step_hit(logic in_diag, int k, logic b, logic s);
    return (b == exp_blank(k)) && (s == exp_strobe(in_diag, k));
  endfunction

  task automatic model_edge(logic b, logic s);
    bit done;
    done = step_hit(m_diag, m_step, b, s) && (m_step == 4);
    m_start = m_pend;
    m_pend  = done && !m_diag;
    if (step_hit(m_diag, m_step, b, s)) m_step = done ? 0 : m_step + 1;
    else m_step = step_hit(m_diag, 0, b, s) ? 1 : 0;
    if (done) m_diag = !m_diag;
  endtask

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one sample, clock it, compare both outputs to the model.
  task automatic drive(logic b, logic s, string tag);
    blank = b;
    strobe = s;
    @(posedge clk);
    model_edge(b, s);
    #1;
    chk({tag, " mode"}, diag_mode, m_diag);
    chk({tag, " start"}, sample_start, m_start);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    blank = 1'b1;
    strobe = 1'b0;
    repeat (2) @(posedge clk);
    m_diag = 0; m_step = 0; m_pend = 0; m_start = 0;
    #1;
    chk("R1 reset mode", diag_mode, 1'b0);
    chk("R1 reset start", sample_start, 1'b0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send_seq(logic to_diag, int upto, string tag);
    for (int k = 0; k < upto; k++) drive(exp_blank(k), exp_strobe(!to_diag, k), tag);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    @(negedge clk);
    do_reset();

    // R2/R3: entry sequence, mode flips exactly on the fifth edge
    send_seq(1'b1, 4, "R3");
    chk("R3 no flip after four steps", diag_mode, 1'b0);
    drive(1'b1, 1'b0, "R2");
    chk("R2 entered diagnostic mode", diag_mode, 1'b1);
    chk("R4 no pulse on entry edge", sample_start, 1'b0);
    drive(1'b1, 1'b1, "R4");
    chk("R4 pulse one edge later", sample_start, 1'b1);
    drive(1'b1, 1'b1, "R4");
    chk("R4 pulse lasts one cycle", sample_start, 1'b0);

    // R6: repeated entry in diagnostic mode is ignored
    send_seq(1'b1, 5, "R6");
    drive(1'b1, 1'b1, "R6");
    chk("R6 repeated entry ignored", diag_mode, 1'b1);

    // R5: return sequence
    send_seq(1'b0, 5, "R5");
    chk("R5 back to normal", diag_mode, 1'b0);
    drive(1'b1, 1'b1, "R5");
    chk("R5 no pulse on exit", sample_start, 1'b0);

    // R6: repeated return in normal mode is ignored
    send_seq(1'b0, 5, "R6");
    drive(1'b0, 1'b1, "R6");
    chk("R6 repeated return ignored", diag_mode, 1'b0);

    // R7: abort at each step with a sample matching no step
    for (int k = 1; k <= 4; k++) begin
      send_seq(1'b1, k, "R7");
      drive(1'b0, 1'b1, "R7");
      for (int j = k; j < 5; j++) drive(exp_blank(j), exp_strobe(1'b0, j), "R7");
      chk("R7 aborted entry has no effect", diag_mode, 1'b0);
    end

    // R7: break at step four with a first-step sample restarts at step 1
    send_seq(1'b1, 3, "R7");
    drive(1'b1, 1'b0, "R7");
    drive(1'b0, 1'b0, "R7");
    drive(1'b1, 1'b0, "R7");
    drive(1'b1, 1'b1, "R7");
    drive(1'b1, 1'b0, "R7");
    chk("R7 restart from step one completes", diag_mode, 1'b1);
    send_seq(1'b0, 5, "R7");
    chk("R7 return after restart", diag_mode, 1'b0);

    // R8: random strobe and blanking traffic with embedded sequences
    for (int n = 0; n < 120; n++) begin
      int op;
      op = $urandom_range(0, 5);
      if (op == 0) send_seq(!m_diag, 5, "R8");
      else if (op == 1) send_seq(!m_diag, $urandom_range(1, 4), "R8");
      else if (op == 2) send_seq(m_diag, 5, "R8");
      else begin
        int len;
        len = $urandom_range(1, 12);
        for (int c = 0; c < len; c++) drive(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R8");
      end
    end

    // R1: reset in the middle of a partial sequence
    send_seq(!m_diag, 3, "R1");
    do_reset();
    drive(1'b1, 1'b1, "R1");
    send_seq(1'b1, 5, "R1");
    chk("R1 progress cleared, full entry works", diag_mode, 1'b1);

    finish_run();
  end

endmodule